// File: doc/BRIEF.md
# Grace-Period Bank Power Controller

This block sequences the power modes of a set of memory banks and of the single charge pump that feeds them. Each bank carries its own down-counter, the grace timer. The timer is reloaded from a per-bank grace value for as long as that bank is being accessed, and it counts down by one every clock once the bank is idle. When the timer runs out, the bank moves to its own programmed fallback mode. A fallback of active keeps the bank powered indefinitely, and that is how the block comes out of reset.

The pump has a second grace timer of the same kind. It is reloaded while any bank is still out of its low-power mode and in any cycle that carries an access. It counts only when every bank has already dropped to standby or sleep. An access to a bank that sits in standby or sleep brings the pump back to active at once. The bank itself returns to active after a programmable wake delay, and that delay differs for sleep and for standby. The ready output is low for that whole delay, so the requester can stall its access.

Top module: `grace_power_ctrl`

## Requirements
- R1: In the first cycle after reset is released, every bank mode and the pump mode read active (2'b11) and ready is high.
- R2: The grace timer of an active bank is reloaded in every cycle in which its access input is high. Once the access input is low, the timer counts down one per clock. With grace value G, the bank's mode changes G+1 clocks after the last clock edge that sampled the access high.
- R3: When a bank's timer has expired, the bank takes its fallback mode. The fallback input is decoded as 2'b01 = standby and 2'b00 = sleep. Mode outputs only ever show 2'b11 active, 2'b01 standby or 2'b00 sleep.
- R4: A fallback input of 2'b11, or the unused code 2'b10, keeps the bank active after its timer has expired.
- R5: The pump timer is reloaded in any clock in which some bank is not in its low-power state, or in which some access input is high. The pump mode is never low while any bank mode reads active.
- R6: Once every bank is low-power and no access is present, the pump timer counts down. With pump grace value P, the pump takes its decoded fallback mode P+1 clocks after the edge at which the last bank dropped, using the same encoding as R3.
- R7: An access to a bank in standby or sleep turns the pump mode active at the first clock edge that samples it. At that same edge ready goes low and the bank mode still shows its low-power value.
- R8: The wake delay is the sleep delay input when the bank was asleep and the standby delay input when it was in standby. With delay D ≥ 1, ready stays low for exactly D cycles. Then the bank mode becomes active and ready returns high. The bank's grace timer restarts from its grace value at that point.
- R9: An access to a bank that is already active reloads its timer while the timer is still running. This adds no ready gap and extends the bank's active time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all timers count on it |
| rst | input | 1 | Synchronous active-high reset |
| bank_access | input | NUM_BANKS | Per-bank access-in-progress level |
| bank_grace | input | NUM_BANKS*GRACE_W | Per-bank grace value, bank i in bits [i*GRACE_W +: GRACE_W] |
| bank_fallback | input | 2*NUM_BANKS | Per-bank fallback code, bank i in bits [2i +: 2] |
| pump_grace | input | GRACE_W | Pump grace value |
| pump_fallback | input | 2 | Pump fallback code |
| wake_stby | input | WAKE_W | Wake delay from standby, in cycles |
| wake_sleep | input | WAKE_W | Wake delay from sleep, in cycles |
| bank_mode | output | 2*NUM_BANKS | Per-bank power mode, bank i in bits [2i +: 2] |
| pump_mode | output | 2 | Pump power mode |
| ready | output | 1 | High when no bank is waking |

## Verification
The bench targets the exact expiry cycle of each timer, one cycle before and one cycle after, for several grace values. An off-by-one in reload or countdown shifts that edge and is caught. Banks whose fallback is active are checked to keep the pump up. A pump that counted while a bank was still active, or that started counting one edge early, would drop ahead of its expected cycle. Wakes from sleep and from standby check the length of the ready gap. Swapping the two delays, or failing to wake the pump first, gives the wrong gap or the wrong mode in the first cycle. An access pulse in the middle of the grace time checks both that the timer is reloaded and that ready stays high. A design that ignored the pulse would drop the bank several cycles early.

// File: rtl/grace_power_pkg.sv
package grace_power_pkg;

    typedef enum logic [1:0] {
        PM_SLEEP   = 2'b00,
        PM_STANDBY = 2'b01,
        PM_ACTIVE  = 2'b11
    } pm_mode_t;

    typedef enum logic [1:0] {
        BK_ON   = 2'b00,
        BK_LOW  = 2'b01,
        BK_WAKE = 2'b10
    } bk_state_t;

    // Fallback code to mode; unused codes keep the unit powered
    function automatic pm_mode_t decode_fallback(input logic [1:0] code);
        case (code)
            2'b00:   return PM_SLEEP;
            2'b01:   return PM_STANDBY;
            default: return PM_ACTIVE;
        endcase
    endfunction

endpackage

// File: rtl/gp_bank_unit.sv
module gp_bank_unit
    import grace_power_pkg::*;
#(
    parameter int GRACE_W = 8,
    parameter int WAKE_W  = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               access,
    input  logic [GRACE_W-1:0] grace,
    input  logic [1:0]         fallback,
    input  logic [WAKE_W-1:0]  wake_stby,
    input  logic [WAKE_W-1:0]  wake_sleep,
    output pm_mode_t           mode,
    output logic               is_low,
    output logic               waking
);

    bk_state_t          state;
    logic [GRACE_W-1:0] grace_cnt;
    logic [WAKE_W-1:0]  wake_cnt;
    pm_mode_t           fb_mode;
    logic [WAKE_W-1:0]  wake_dly;

    always_comb begin
        fb_mode  = decode_fallback(fallback);
        wake_dly = (mode == PM_SLEEP) ? wake_sleep : wake_stby;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= BK_ON;
            mode      <= PM_ACTIVE;
            grace_cnt <= grace;
            wake_cnt  <= '0;
        end else begin
            case (state)
                BK_ON: begin
                    if (access) begin
                        grace_cnt <= grace;
                    end else if (grace_cnt != '0) begin
                        grace_cnt <= grace_cnt - 1'b1;
                    end else if (fb_mode != PM_ACTIVE) begin
                        mode  <= fb_mode;
                        state <= BK_LOW;
                    end
                end
                BK_LOW: begin
                    if (access) begin
                        if (wake_dly == '0) begin
                            mode      <= PM_ACTIVE;
                            state     <= BK_ON;
                            grace_cnt <= grace;
                        end else begin
                            wake_cnt <= wake_dly;
                            state    <= BK_WAKE;
                        end
                    end
                end
                BK_WAKE: begin
                    if (wake_cnt <= 1) begin
                        wake_cnt  <= '0;
                        mode      <= PM_ACTIVE;
                        state     <= BK_ON;
                        grace_cnt <= grace;
                    end else begin
                        wake_cnt <= wake_cnt - 1'b1;
                    end
                end
                default: begin
                    mode      <= PM_ACTIVE;
                    state     <= BK_ON;
                    grace_cnt <= grace;
                end
            endcase
        end
    end

    assign is_low = (state == BK_LOW);
    assign waking = (state == BK_WAKE);

endmodule

// File: rtl/gp_pump_unit.sv
module gp_pump_unit
    import grace_power_pkg::*;
#(
    parameter int GRACE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hold,
    input  logic [GRACE_W-1:0] grace,
    input  logic [1:0]         fallback,
    output pm_mode_t           mode
);

    logic [GRACE_W-1:0] grace_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode      <= PM_ACTIVE;
            grace_cnt <= grace;
        end else if (hold) begin
            mode      <= PM_ACTIVE;
            grace_cnt <= grace;
        end else if (grace_cnt != '0) begin
            grace_cnt <= grace_cnt - 1'b1;
        end else begin
            mode <= decode_fallback(fallback);
        end
    end

endmodule

// File: rtl/grace_power_ctrl.sv
module grace_power_ctrl
    import grace_power_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int GRACE_W   = 8,
    parameter int WAKE_W    = 6
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_BANKS-1:0]         bank_access,
    input  logic [NUM_BANKS*GRACE_W-1:0] bank_grace,
    input  logic [2*NUM_BANKS-1:0]       bank_fallback,
    input  logic [GRACE_W-1:0]           pump_grace,
    input  logic [1:0]                   pump_fallback,
    input  logic [WAKE_W-1:0]            wake_stby,
    input  logic [WAKE_W-1:0]            wake_sleep,
    output logic [2*NUM_BANKS-1:0]       bank_mode,
    output logic [1:0]                   pump_mode,
    output logic                         ready
);

    logic [NUM_BANKS-1:0] low_vec;
    logic [NUM_BANKS-1:0] wake_vec;
    logic                 pump_hold;
    pm_mode_t             pump_m;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        pm_mode_t m;
        gp_bank_unit #(
            .GRACE_W (GRACE_W),
            .WAKE_W  (WAKE_W)
        ) u_bank (
            .clk        (clk),
            .rst        (rst),
            .access     (bank_access[b]),
            .grace      (bank_grace[b*GRACE_W +: GRACE_W]),
            .fallback   (bank_fallback[2*b +: 2]),
            .wake_stby  (wake_stby),
            .wake_sleep (wake_sleep),
            .mode       (m),
            .is_low     (low_vec[b]),
            .waking     (wake_vec[b])
        );
        assign bank_mode[2*b +: 2] = m;
    end

    // Pump stays up while any bank is out of low power or being accessed
    assign pump_hold = !(&low_vec) || (|bank_access);

    gp_pump_unit #(
        .GRACE_W (GRACE_W)
    ) u_pump (
        .clk      (clk),
        .rst      (rst),
        .hold     (pump_hold),
        .grace    (pump_grace),
        .fallback (pump_fallback),
        .mode     (pump_m)
    );

    assign pump_mode = pump_m;
    assign ready     = !(|wake_vec);

endmodule

// File: rtl/grace_power_ctrl_chk.sv
module grace_power_ctrl_chk #(
    parameter int NUM_BANKS = 4,
    parameter int GRACE_W   = 8,
    parameter int WAKE_W    = 6
) (
    input logic                         clk,
    input logic                         rst,
    input logic [NUM_BANKS-1:0]         bank_access,
    input logic [NUM_BANKS*GRACE_W-1:0] bank_grace,
    input logic [WAKE_W-1:0]            wake_stby,
    input logic [WAKE_W-1:0]            wake_sleep,
    input logic [2*NUM_BANKS-1:0]       bank_mode,
    input logic [1:0]                   pump_mode,
    input logic                         ready
);

    logic any_bank_on;
    logic grace_seen;

    always_comb begin
        any_bank_on = 1'b0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (bank_mode[2*i +: 2] == 2'b11) any_bank_on = 1'b1;
        end
        grace_seen = |bank_grace;
    end

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (&bank_mode) && pump_mode == 2'b11 && ready); // R1

    AST_PUMP_UP_ON_ACCESS: assert property (@(posedge clk) disable iff (rst)
        (|bank_access) |=> pump_mode == 2'b11); // R7

    AST_PUMP_LOW_NEEDS_BANKS_LOW: assert property (@(posedge clk) disable iff (rst)
        pump_mode != 2'b11 |-> !any_bank_on); // R5

    AST_PUMP_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        pump_mode != 2'b10 || !grace_seen && pump_mode != 2'b10); // R3

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_chk
        AST_BANK_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
            bank_mode[2*i +: 2] != 2'b10); // R3

        AST_ACCESS_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
            (bank_access[i] && bank_mode[2*i +: 2] == 2'b11)
            |=> bank_mode[2*i +: 2] == 2'b11); // R2

        AST_WAKE_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
            (bank_access[i] && bank_mode[2*i +: 2] != 2'b11 && ready
             && wake_stby != '0 && wake_sleep != '0) |=> !ready); // R8
    end

endmodule

bind grace_power_ctrl grace_power_ctrl_chk #(
    .NUM_BANKS (NUM_BANKS),
    .GRACE_W   (GRACE_W),
    .WAKE_W    (WAKE_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bank_access (bank_access),
    .bank_grace  (bank_grace),
    .wake_stby   (wake_stby),
    .wake_sleep  (wake_sleep),
    .bank_mode   (bank_mode),
    .pump_mode   (pump_mode),
    .ready       (ready)
);

// File: tb/grace_power_ctrl_bench.sv
module grace_power_ctrl_bench;

    localparam int NB = 4;
    localparam int GW = 8;
    localparam int WW = 6;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NB-1:0]   bank_access = '0;
    logic [NB*GW-1:0] bank_grace = {8'd1, 8'd2, 8'd5, 8'd3};
    logic [2*NB-1:0] bank_fallback = {2'b01, 2'b11, 2'b00, 2'b01};
    logic [GW-1:0]   pump_grace = 8'd4;
    logic [1:0]      pump_fallback = 2'b00;
    logic [WW-1:0]   wake_stby = 6'd2;
    logic [WW-1:0]   wake_sleep = 6'd5;
    logic [2*NB-1:0] bank_mode;
    logic [1:0]      pump_mode;
    logic            ready;

    grace_power_ctrl #(
        .NUM_BANKS (NB),
        .GRACE_W   (GW),
        .WAKE_W    (WW)
    ) u_grace_power_ctrl (
        .clk           (clk),
        .rst           (rst),
        .bank_access   (bank_access),
        .bank_grace    (bank_grace),
        .bank_fallback (bank_fallback),
        .pump_grace    (pump_grace),
        .pump_fallback (pump_fallback),
        .wake_stby     (wake_stby),
        .wake_sleep    (wake_sleep),
        .bank_mode     (bank_mode),
        .pump_mode     (pump_mode),
        .ready         (ready)
    );

    always #2 clk = ~clk;

    typedef struct {
        int         due;
        int         kind;   // 0 bank mode, 1 pump mode, 2 ready
        int         idx;
        logic [1:0] val;
        string      req;
    } exp_t;

    exp_t sb_q[$];
    int   cyc = 0;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_item(input int due, input int kind, input int idx,
                               input logic [1:0] val, input string req);
        exp_t e;
        e.due = due; e.kind = kind; e.idx = idx; e.val = val; e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic wait_cyc(input int c);
        while (cyc != c) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Monitor: compares scoreboard items when their cycle comes up
    always @(negedge clk) begin
        if (!finished) begin
            while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
                exp_t e;
                logic [1:0] act;
                e = sb_q.pop_front();
                case (e.kind)
                    0:       act = bank_mode[2*e.idx +: 2];
                    1:       act = pump_mode;
                    default: act = {1'b0, ready};
                endcase
                n_checks++;
                if (e.due != cyc || act !== e.val) begin
                    n_errors++;
                    $display("FAIL %s: kind %0d idx %0d cycle %0d actual %b expected %b",
                             e.req, e.kind, e.idx, e.due, act, e.val);
                end
            end
        end
    end

    initial begin
        int base;
        int t;
        int t2;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        base = cyc;
        // R1: reset state
        for (int b = 0; b < NB; b++) expect_item(base, 0, b, 2'b11, "R1");
        expect_item(base, 1, 0, 2'b11, "R1");
        expect_item(base, 2, 0, 2'b01, "R1");
        // R2/R3: expiry at G+1 for each grace value
        expect_item(base + 2, 0, 3, 2'b01, "R3");
        expect_item(base + 3, 0, 0, 2'b11, "R2");
        expect_item(base + 4, 0, 0, 2'b01, "R3");
        expect_item(base + 5, 0, 1, 2'b11, "R2");
        expect_item(base + 6, 0, 1, 2'b00, "R3");
        // R4: active fallback keeps bank 2 up; R5: pump held by it
        expect_item(base + 20, 0, 2, 2'b11, "R4");
        expect_item(base + 30, 1, 0, 2'b11, "R5");
        expect_item(base + 30, 0, 2, 2'b11, "R4");
        wait_cyc(base + 30);
        bank_fallback[5:4] = 2'b01;
        expect_item(base + 31, 0, 2, 2'b01, "R3");
        // R6: pump drops P+1 cycles after the last bank
        expect_item(base + 35, 1, 0, 2'b11, "R6");
        expect_item(base + 36, 1, 0, 2'b00, "R6");

        // R7/R8: wake bank 1 from sleep
        t = base + 40;
        wait_cyc(t);
        bank_access[1] = 1'b1;
        expect_item(t + 1, 1, 0, 2'b11, "R7");
        expect_item(t + 1, 0, 1, 2'b00, "R7");
        expect_item(t + 1, 2, 0, 2'b00, "R7");
        expect_item(t + 5, 0, 1, 2'b00, "R8");
        expect_item(t + 5, 2, 0, 2'b00, "R8");
        expect_item(t + 6, 0, 1, 2'b11, "R8");
        expect_item(t + 6, 2, 0, 2'b01, "R8");
        expect_item(t + 11, 0, 1, 2'b11, "R8");
        expect_item(t + 12, 0, 1, 2'b00, "R8");
        expect_item(t + 16, 1, 0, 2'b11, "R5");
        expect_item(t + 17, 1, 0, 2'b00, "R6");
        wait_cyc(t + 1);
        bank_access[1] = 1'b0;

        // R8: standby wake of bank 0, R2: held access, R9: reload pulse
        t2 = base + 70;
        wait_cyc(t2);
        bank_access[0] = 1'b1;
        expect_item(t2 + 1, 2, 0, 2'b00, "R7");
        expect_item(t2 + 2, 0, 0, 2'b01, "R8");
        expect_item(t2 + 2, 2, 0, 2'b00, "R8");
        expect_item(t2 + 3, 0, 0, 2'b11, "R8");
        expect_item(t2 + 3, 2, 0, 2'b01, "R8");
        expect_item(t2 + 8, 0, 0, 2'b11, "R2");
        expect_item(t2 + 11, 2, 0, 2'b01, "R9");
        expect_item(t2 + 12, 0, 0, 2'b11, "R9");
        expect_item(t2 + 12, 2, 0, 2'b01, "R9");
        expect_item(t2 + 14, 0, 0, 2'b11, "R9");
        expect_item(t2 + 15, 0, 0, 2'b01, "R9");
        wait_cyc(t2 + 8);
        bank_access[0] = 1'b0;
        wait_cyc(t2 + 10);
        bank_access[0] = 1'b1;
        wait_cyc(t2 + 11);
        bank_access[0] = 1'b0;

        wait_cyc(t2 + 20);
        finished = 1'b1;
        if (sb_q.size() != 0) begin
            n_errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #20000;
        finished = 1'b1;
        n_errors++;
        $display("FAIL watchdog: cycle %0d actual timeout expected completion", cyc);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule